// File: doc/BRIEF.md
# Completion-Detecting Sequential Adder

This block adds two WIDTH-bit operands and a carry-in. It does not wait a fixed worst-case carry time. Instead it tells the surrounding logic when the result is final. Each bit position keeps a three-valued carry-out: resolved-one, resolved-zero or unresolved.

A position whose two operand bits are equal either generates or kills a carry, so it resolves as soon as the operands are loaded. A position whose operand bits differ passes its carry through. It stays unresolved until the carry arriving from the position below it is resolved, and then it copies that carry. The resolved state moves up such a pass-through run by one position per clock. The bit-0 position sees the carry-in, which is always resolved.

A check over every position raises `done` once none of them is unresolved. The latency therefore tracks the longest pass-through run in the data rather than the operand width. Only when every position passes its carry through is the latency as long as that of a bit-serial ripple.

A one-cycle `start` loads the operands and the carry-in, and it restarts the block at any time. `done` is a registered flag that stays high until the next `start`. While `done` is high, `sum` and `carry_out` hold the full result.

Top module: `cmpl_adder`

## Requirements
- R1: After a synchronous reset, and before any `start`, `done`, `sum` and `carry_out` are all 0.
- R2: While `done` is high, {`carry_out`, `sum`} equals `op_a + op_b + carry_in` as sampled on the clock edge where `start` was high.
- R3: Let L be the length of the longest run of adjacent bit positions where `op_a` and `op_b` differ (L = 0 if there is none). Count the clock edge that samples `start` as edge 1. `done` first reads high after edge L+1.
- R4: Once high, `done` stays high until a clock edge samples `start`. If the new operands give L > 0, `done` is low after that edge.
- R5: A position whose two operand bits are equal holds a resolved carry equal to those bits from the loading edge onward.
- R6: A position whose operand bits differ stays unresolved while the carry into it is unresolved. It takes that carry's value one clock after the carry resolves.
- R7: A resolved carry keeps its value until the next `start`, so `sum` and `carry_out` stay stable while `done` is high.
- R8: A `start` raised before `done` abandons the running addition. The result and latency then follow R2 and R3 for the new operands only.
- R9: When every position passes its carry through (`op_a` = ~`op_b`), `done` rises after edge WIDTH+1.
- R10: `done` is never high while any position is unresolved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Loads the operands and carry-in, and restarts the resolution |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Registered sum |
| carry_out | output | 1 | Registered carry out of the top bit |
| done | output | 1 | High while the result is final |

## Verification
Some behaviours are checked by assertions on every cycle:
- generate and kill positions are resolved,
- an unresolved position waits for its neighbour and then copies it,
- a resolved carry stays fixed,
- `done` implies that every position is resolved and that the sum is correct, and
- `done` holds until the next `start`.

Other behaviours can only be shown by the bench's scenarios. These are the exact cycle on which `done` rises, the reset state, and the abort and restart behaviour. The bench sweeps every operand pair and both carry-in values at width 6, and it computes the expected sum and the longest pass-through run arithmetically.

// File: rtl/cmpl_adder_pkg.sv
`timescale 1ns/1ps
package cmpl_adder_pkg;

  // Three-valued carry: known=0 means unresolved, val is meaningful only when known=1
  typedef struct packed {
    logic known;
    logic val;
  } carry_t;

  localparam carry_t CARRY_ZERO = '{known: 1'b1, val: 1'b0};
  localparam carry_t CARRY_OPEN = '{known: 1'b0, val: 1'b0};

  // Equal bits generate (1,1) or kill (0,0) by themselves; unequal bits propagate
  function automatic carry_t classify(input logic a, input logic b);
    carry_t c;
    if (a == b) c = '{known: 1'b1, val: a};
    else        c = CARRY_OPEN;
    return c;
  endfunction

endpackage

// File: rtl/cmpl_adder_cell.sv
`timescale 1ns/1ps
module cmpl_adder_cell
  import cmpl_adder_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load,
  input  logic   a_ld,
  input  logic   b_ld,
  input  carry_t cin_now,
  output logic   a_q,
  output logic   b_q,
  output carry_t c_q,
  output carry_t c_nxt
);

  always_comb begin
    if (load)                c_nxt = classify(a_ld, b_ld);
    else if (c_q.known)      c_nxt = c_q;
    else if (cin_now.known)  c_nxt = cin_now;
    else                     c_nxt = c_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
      c_q <= CARRY_ZERO;
    end else begin
      if (load) begin
        a_q <= a_ld;
        b_q <= b_ld;
      end
      c_q <= c_nxt;
    end
  end

  AST_GK_RESOLVED: assert property (@(posedge clk) disable iff (rst)
    (a_q == b_q) |-> (c_q.known && c_q.val == a_q)); // R5
  AST_PROP_WAITS: assert property (@(posedge clk) disable iff (rst)
    (!load && !c_q.known && !cin_now.known) |=> !c_q.known); // R6
  AST_PROP_TAKES: assert property (@(posedge clk) disable iff (rst)
    (!load && !c_q.known && cin_now.known) |=> (c_q.known && c_q.val == $past(cin_now.val))); // R6
  AST_RESOLVED_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && c_q.known) |=> (c_q.known && $stable(c_q.val))); // R7

endmodule

// File: rtl/cmpl_adder_done.sv
`timescale 1ns/1ps
module cmpl_adder_done #(
  parameter int WIDTH = 16,
  parameter int GROUP = 4
) (
  input  logic [WIDTH-1:0] known,
  output logic             all_known
);

  localparam int NGRP = (WIDTH + GROUP - 1) / GROUP;
  localparam int PADW = NGRP * GROUP;

  logic [PADW-1:0] padded;
  logic [NGRP-1:0] grp_ok;

  assign padded = {{(PADW-WIDTH){1'b1}}, known};

  // Two-level reduction: per-group AND, then across groups
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_ok[g] = &padded[g*GROUP +: GROUP];
  end

  assign all_known = &grp_ok;

endmodule

// File: rtl/cmpl_adder.sv
`timescale 1ns/1ps
module cmpl_adder
  import cmpl_adder_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  output logic [WIDTH-1:0] sum,
  output logic             carry_out,
  output logic             done
);

  logic [WIDTH-1:0]   a_q, b_q, a_nxt, b_nxt;
  carry_t [WIDTH-1:0] c_q, c_nxt;
  logic [WIDTH-1:0]   known_q, known_nxt, cin_val_nxt;
  logic               cin_q, cin_nxt, all_nxt, armed;

  assign cin_nxt = start ? carry_in : cin_q;
  assign a_nxt   = start ? op_a : a_q;
  assign b_nxt   = start ? op_b : b_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_pos
    carry_t cin_now;
    if (i == 0) begin : g_lsb
      assign cin_now        = '{known: 1'b1, val: cin_q};
      assign cin_val_nxt[i] = cin_nxt;
    end else begin : g_up
      assign cin_now        = c_q[i-1];
      assign cin_val_nxt[i] = c_nxt[i-1].val;
    end

    cmpl_adder_cell u_cell (
      .clk     (clk),
      .rst     (rst),
      .load    (start),
      .a_ld    (op_a[i]),
      .b_ld    (op_b[i]),
      .cin_now (cin_now),
      .a_q     (a_q[i]),
      .b_q     (b_q[i]),
      .c_q     (c_q[i]),
      .c_nxt   (c_nxt[i])
    );

    assign known_q[i]   = c_q[i].known;
    assign known_nxt[i] = c_nxt[i].known;
  end

  cmpl_adder_done #(.WIDTH(WIDTH)) u_done (
    .known     (known_nxt),
    .all_known (all_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum       <= '0;
      carry_out <= 1'b0;
      done      <= 1'b0;
      armed     <= 1'b0;
      cin_q     <= 1'b0;
    end else begin
      sum       <= a_nxt ^ b_nxt ^ cin_val_nxt;
      carry_out <= c_nxt[WIDTH-1].val;
      cin_q     <= cin_nxt;
      if (start) begin
        armed <= 1'b1;
        done  <= all_nxt;
      end else begin
        done  <= done | (armed & all_nxt);
      end
    end
  end

  AST_DONE_RESOLVED: assert property (@(posedge clk) disable iff (rst)
    done |-> (&known_q)); // R10
  AST_DONE_SUM: assert property (@(posedge clk) disable iff (rst)
    done |-> ({carry_out, sum} == ({1'b0, a_q} + {1'b0, b_q} + {{WIDTH{1'b0}}, cin_q}))); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R4
  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> ($stable(sum) && $stable(carry_out))); // R7

endmodule

// File: tb/cmpl_adder_tb.sv
`timescale 1ns/1ps
module cmpl_adder_tb;

  localparam int W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         carry_in = 1'b0;
  logic [W-1:0] sum;
  logic         carry_out, done;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  cmpl_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .carry_in(carry_in), .sum(sum), .carry_out(carry_out), .done(done)
  );

  function automatic int longest_run(input logic [W-1:0] p);
    int best = 0;
    int cur  = 0;
    for (int i = 0; i < W; i++) begin
      if (p[i]) begin cur++; if (cur > best) best = cur; end
      else cur = 0;
    end
    return best;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch an addition; return the number of edges until done reads high
  task automatic launch(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, output int edges);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    while (!done && edges < W + 4) begin
      @(negedge clk);
      edges++;
    end
  endtask

  task automatic add_check(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci, input string tag);
    int edges;
    int exp_sum;
    int exp_lat;
    exp_sum = int'(a) + int'(b) + int'(ci);
    exp_lat = longest_run(a ^ b) + 1;
    launch(a, b, ci, edges);
    // R2 and R10: result final once done
    check({carry_out, sum} == exp_sum[W:0], {tag, " R2"}, int'({carry_out, sum}), exp_sum);
    // R3 R5 R6: first edge with done equals longest run plus one
    check(edges == exp_lat, {tag, " R3 R6"}, edges, exp_lat);
  endtask

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int edges;
    logic [W:0] snap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state before any start
    check(done == 1'b0, "R1 done", int'(done), 0);
    check(sum == '0 && carry_out == 1'b0, "R1 result", int'({carry_out, sum}), 0);
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1 no start", int'(done), 0);

    // R5: all generate/kill positions finish after a single edge
    add_check(6'b101101, 6'b101101, 1'b1, "R5");
    // R9: worst case, every position propagates
    add_check(6'b010101, 6'b101010, 1'b1, "R9");
    add_check(6'b111111, 6'b000000, 1'b0, "R9");

    // R4 R7: done and result hold until the next start
    snap = {carry_out, sum};
    repeat (4) @(negedge clk);
    check(done == 1'b1, "R4 hold", int'(done), 1);
    check({carry_out, sum} == snap, "R7 stable", int'({carry_out, sum}), int'(snap));

    // R4: start while done with L>0 drops done after the loading edge
    @(negedge clk);
    op_a = 6'b000111; op_b = 6'b000100; carry_in = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R4 restart", int'(done), 0);
    repeat (4) @(negedge clk);
    check(done && {carry_out, sum} == 7'd11, "R4 R2 restart", int'({carry_out, sum}), 11);

    // R8: abort a long chain after two edges, then restart with new operands
    @(negedge clk);
    op_a = 6'b000000; op_b = 6'b111111; carry_in = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    add_check(6'b001100, 6'b000110, 1'b0, "R8");

    // Exhaustive sweep: R2 and R3 for every operand pair and carry-in
    for (int ci = 0; ci < 2; ci++) begin
      for (int a = 0; a < (1 << W); a++) begin
        for (int b = 0; b < (1 << W); b++) begin
          add_check(W'(a), W'(b), ci[0], "sweep");
        end
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule